// File: doc/BRIEF.md
# Scanning Delay-and-Sum Beamformer

This block takes one signed 16-bit PCM sample from every microphone of an array at the audio frame rate. It steers a beam toward each of a full circle of directions in turn. Every channel goes into its own circular history buffer. For each direction the block adds one delayed sample from each microphone, where the delay is a whole number of sample periods read from a constant table indexed by direction and microphone. A single accumulate path works through every direction/microphone pair, one pair per fast clock, after each accepted frame.

For each direction the block also keeps a running sum of squared beam samples over an averaging window. The window is short or long, selected by an input. When a window closes, the block reports the direction with the largest energy and that energy value. Since every direction's sum covers the same number of samples, this sum is the mean square scaled by a constant. The block also returns the beam sample of one direction chosen by the host and the raw sample of one chosen microphone. A later stage takes the square root and drives the host link.

Top module: `bf_scan_beamformer`

## Requirements
- R1: While reset is high and after it falls, done, dom_valid, beam_out, mic_out, dom_angle and dom_energy are zero, and all history buffers read as zero.
- R2: A frame is accepted when sample_valid is high while the block is idle. Channel m is bits [16m+15:16m] of sample_in. mic_out then holds the channel selected by sel_mic for that frame.
- R3: For direction a, the beam is the sum over microphones m of x_m[n-d], with d = (a*(2m+1)+3m) mod 64. Here x_m[n] is the frame just accepted, and frames older than the first accepted frame count as zero. beam_out holds the beam of the direction given by sel_angle.
- R4: done is high for exactly one clock, NUM_ANGLES*NUM_MICS clocks after the accepting edge. beam_out and mic_out are final when done is high.
- R5: sample_valid is ignored while a scan runs. It changes neither the history buffers nor mic_out.
- R6: In short mode a window is WINDOW_LEN frames. At its end, dom_energy is the sum, over that window, of the squared beam of the reported direction.
- R7: In long mode a window is WINDOW_LEN*LONG_MULT frames. long_mode is sampled at the first frame of each window, so a change in the middle of a window takes effect only at the next window.
- R8: dom_angle is the direction with the largest window energy. A tie goes to the lowest direction index.
- R9: dom_valid pulses together with done of the last frame of a window. dom_angle and dom_energy change at no other time.
- R10: The history buffers wrap modulo 64. Beams stay correct after more than 64 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock, well above frame rate |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Frame present on sample_in |
| sample_in | input | NUM_MICS*SAMPLE_W | Packed signed samples, channel 0 in low bits |
| long_mode | input | 1 | 1 selects the long averaging window |
| sel_angle | input | ANG_W | Direction whose beam drives beam_out |
| sel_mic | input | MIC_W | Channel copied to mic_out |
| done | output | 1 | One-clock pulse at end of scan |
| beam_out | output | BEAM_W | Beam sample of the selected direction |
| mic_out | output | SAMPLE_W | Raw sample of the selected channel |
| dom_valid | output | 1 | One-clock pulse when a window closes |
| dom_angle | output | ANG_W | Direction of largest window energy |
| dom_energy | output | EN_W | Window sum of squares of that direction |

## Verification
A table of mixed frames is sent with a different selected direction and microphone for each frame. The frames include full-scale positive and negative values, alternating signs and sparse impulses. These tell a wrong tap offset or channel order apart from a wrong sign extension or overflow in the sum. An all-zero window after reset forces an energy tie in every direction, which exposes any argmax that does not favour the lowest index. A frame with junk injected during its scan shows whether a busy frame is dropped. A long_mode change in the middle of a window, followed by a long window, separates window-length selection from the moment the mode is sampled. A ramp of more than 64 frames exercises buffer wrap-around.

// File: rtl/bf_pkg.sv
package bf_pkg;

    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_state_e;

    // Per-cycle control carried from the sequencer to the datapath
    typedef struct packed {
        logic step;        // one direction/microphone pair processed this cycle
        logic beam_done;   // last microphone of the current direction
        logic last_angle;  // current direction is the final one
        logic win_end;     // current frame closes the averaging window
    } step_flags_t;

    // Whole-sample tap offset for direction a, microphone m
    function automatic int tap_delay(input int a, input int m, input int depth);
        return (a * (2 * m + 1) + 3 * m) % depth;
    endfunction

    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bf_scan_ctrl.sv
module bf_scan_ctrl
    import bf_pkg::*;
#(
    parameter int NUM_ANGLES = 60,
    parameter int NUM_MICS   = 4,
    parameter int WINDOW_LEN = 6000,
    parameter int LONG_MULT  = 8,
    parameter int ANG_W      = bits_for(NUM_ANGLES),
    parameter int MIC_W      = bits_for(NUM_MICS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    input  logic             long_mode,
    output logic             accept,
    output logic [ANG_W-1:0] angle,
    output logic [MIC_W-1:0] mic,
    output step_flags_t      flags,
    output logic             done
);
    localparam int LONG_LEN  = WINDOW_LEN * LONG_MULT;
    localparam int CNT_W     = bits_for(LONG_LEN);
    localparam int SHORT_LIM = WINDOW_LEN - 1;
    localparam int LONG_LIM  = LONG_LEN - 1;

    scan_state_e      state;
    logic [CNT_W-1:0] win_cnt;
    logic             mode_q;
    logic             win_end_q;
    logic             mode_now;
    logic [CNT_W-1:0] win_lim;

    always_comb begin
        accept           = (state == SCAN_IDLE) && sample_valid;
        mode_now         = (win_cnt == '0) ? long_mode : mode_q;
        win_lim          = mode_now ? CNT_W'(LONG_LIM) : CNT_W'(SHORT_LIM);
        flags.step       = (state == SCAN_RUN);
        flags.beam_done  = (state == SCAN_RUN) && (int'(mic) == NUM_MICS - 1);
        flags.last_angle = (int'(angle) == NUM_ANGLES - 1);
        flags.win_end    = win_end_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SCAN_IDLE;
            angle     <= '0;
            mic       <= '0;
            win_cnt   <= '0;
            mode_q    <= 1'b0;
            win_end_q <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state  <= SCAN_RUN;
                angle  <= '0;
                mic    <= '0;
                mode_q <= mode_now;
                if (win_cnt == win_lim) begin
                    win_cnt   <= '0;
                    win_end_q <= 1'b1;
                end else begin
                    win_cnt   <= win_cnt + 1'b1;
                    win_end_q <= 1'b0;
                end
            end else if (state == SCAN_RUN) begin
                if (int'(mic) == NUM_MICS - 1) begin
                    mic <= '0;
                    if (int'(angle) == NUM_ANGLES - 1) begin
                        state <= SCAN_IDLE;
                        done  <= 1'b1;
                    end else begin
                        angle <= angle + 1'b1;
                    end
                end else begin
                    mic <= mic + 1'b1;
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_ANGLE_RANGE: assert property (@(posedge clk) disable iff (rst)
        flags.step |-> (int'(angle) < NUM_ANGLES && int'(mic) < NUM_MICS)); // R3

endmodule

// File: rtl/bf_delay_store.sv
module bf_delay_store
    import bf_pkg::*;
#(
    parameter int NUM_ANGLES = 60,
    parameter int NUM_MICS   = 4,
    parameter int SAMPLE_W   = 16,
    parameter int DEPTH      = 64,
    parameter int ANG_W      = bits_for(NUM_ANGLES),
    parameter int MIC_W      = bits_for(NUM_MICS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [NUM_MICS*SAMPLE_W-1:0] wr_data,
    input  logic [ANG_W-1:0]             rd_angle,
    input  logic [MIC_W-1:0]             rd_mic,
    output logic signed [SAMPLE_W-1:0]   rd_data
);
    localparam int PTR_W = bits_for(DEPTH);   // DEPTH must be a power of two

    logic [PTR_W-1:0]           wptr;
    logic [PTR_W-1:0]           tap_rom [NUM_ANGLES][NUM_MICS];
    logic signed [SAMPLE_W-1:0] ch_rd   [NUM_MICS];

    // Constant tap table, one entry per direction and microphone
    for (genvar a = 0; a < NUM_ANGLES; a++) begin : g_rom_a
        for (genvar m = 0; m < NUM_MICS; m++) begin : g_rom_m
            assign tap_rom[a][m] = PTR_W'(tap_delay(a, m, DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '1;
        end else if (wr_en) begin
            wptr <= wptr + 1'b1;
        end
    end

    // One circular buffer per channel: write port at frame rate, read port per step
    for (genvar m = 0; m < NUM_MICS; m++) begin : g_chan
        logic signed [SAMPLE_W-1:0] ram [DEPTH];
        logic [PTR_W-1:0]           rd_addr;

        always_comb rd_addr = wptr - tap_rom[rd_angle][m];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
            end else if (wr_en) begin
                ram[wptr + 1'b1] <= wr_data[m*SAMPLE_W +: SAMPLE_W];
            end
        end

        assign ch_rd[m] = ram[rd_addr];
    end

    assign rd_data = ch_rd[rd_mic];

endmodule

// File: rtl/bf_power_track.sv
module bf_power_track
    import bf_pkg::*;
#(
    parameter int NUM_ANGLES = 60,
    parameter int BEAM_W     = 18,
    parameter int EN_W       = 50,
    parameter int ANG_W      = bits_for(NUM_ANGLES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  step_flags_t              flags,
    input  logic [ANG_W-1:0]         angle,
    input  logic signed [BEAM_W-1:0] beam,
    output logic                     dom_valid,
    output logic [ANG_W-1:0]         dom_angle,
    output logic [EN_W-1:0]          dom_energy
);
    localparam int SQ_W = 2 * BEAM_W;

    logic [EN_W-1:0]        energy [NUM_ANGLES];
    logic [EN_W-1:0]        best_e;
    logic [ANG_W-1:0]       best_a;
    logic signed [SQ_W-1:0] prod;
    logic [EN_W-1:0]        total;
    logic                   take;

    always_comb begin
        prod  = SQ_W'(beam) * SQ_W'(beam);
        total = energy[angle] + {{(EN_W-SQ_W){1'b0}}, prod};
        // strict compare keeps the lowest index on a tie
        take  = (angle == '0) || (total > best_e);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ANGLES; i++) energy[i] <= '0;
            best_e     <= '0;
            best_a     <= '0;
            dom_valid  <= 1'b0;
            dom_angle  <= '0;
            dom_energy <= '0;
        end else begin
            dom_valid <= 1'b0;
            if (flags.beam_done) begin
                if (flags.win_end) begin
                    energy[angle] <= '0;
                    if (take) begin
                        best_e <= total;
                        best_a <= angle;
                    end
                    if (flags.last_angle) begin
                        dom_valid  <= 1'b1;
                        dom_angle  <= take ? angle : best_a;
                        dom_energy <= take ? total : best_e;
                    end
                end else begin
                    energy[angle] <= total;
                end
            end
        end
    end

    AST_DOM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dom_valid |-> ($stable(dom_angle) && $stable(dom_energy))); // R9

    AST_DOM_RANGE: assert property (@(posedge clk) disable iff (rst)
        dom_valid |-> (int'(dom_angle) < NUM_ANGLES)); // R8

endmodule

// File: rtl/bf_scan_beamformer.sv
module bf_scan_beamformer
    import bf_pkg::*;
#(
    parameter int NUM_MICS   = 4,
    parameter int NUM_ANGLES = 60,
    parameter int SAMPLE_W   = 16,
    parameter int DEPTH      = 64,
    parameter int WINDOW_LEN = 6000,
    parameter int LONG_MULT  = 8,
    parameter int ANG_W      = bits_for(NUM_ANGLES),
    parameter int MIC_W      = bits_for(NUM_MICS),
    parameter int BEAM_W     = SAMPLE_W + bits_for(NUM_MICS),
    parameter int EN_W       = 2 * BEAM_W + bits_for(WINDOW_LEN * LONG_MULT) + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sample_valid,
    input  logic [NUM_MICS*SAMPLE_W-1:0] sample_in,
    input  logic                         long_mode,
    input  logic [ANG_W-1:0]             sel_angle,
    input  logic [MIC_W-1:0]             sel_mic,
    output logic                         done,
    output logic signed [BEAM_W-1:0]     beam_out,
    output logic signed [SAMPLE_W-1:0]   mic_out,
    output logic                         dom_valid,
    output logic [ANG_W-1:0]             dom_angle,
    output logic [EN_W-1:0]              dom_energy
);
    logic                       accept;
    logic [ANG_W-1:0]           cur_angle;
    logic [MIC_W-1:0]           cur_mic;
    step_flags_t                flags;
    logic signed [SAMPLE_W-1:0] tap_sample;
    logic signed [BEAM_W-1:0]   acc;
    logic signed [BEAM_W-1:0]   beam_now;

    bf_scan_ctrl #(
        .NUM_ANGLES(NUM_ANGLES), .NUM_MICS(NUM_MICS),
        .WINDOW_LEN(WINDOW_LEN), .LONG_MULT(LONG_MULT),
        .ANG_W(ANG_W), .MIC_W(MIC_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .long_mode(long_mode),
        .accept(accept), .angle(cur_angle), .mic(cur_mic), .flags(flags), .done(done)
    );

    bf_delay_store #(
        .NUM_ANGLES(NUM_ANGLES), .NUM_MICS(NUM_MICS), .SAMPLE_W(SAMPLE_W),
        .DEPTH(DEPTH), .ANG_W(ANG_W), .MIC_W(MIC_W)
    ) u_store (
        .clk(clk), .rst(rst), .wr_en(accept), .wr_data(sample_in),
        .rd_angle(cur_angle), .rd_mic(cur_mic), .rd_data(tap_sample)
    );

    always_comb beam_now = acc + {{(BEAM_W-SAMPLE_W){tap_sample[SAMPLE_W-1]}}, tap_sample};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            beam_out <= '0;
            mic_out  <= '0;
        end else begin
            if (accept) begin
                acc     <= '0;
                mic_out <= sample_in[sel_mic*SAMPLE_W +: SAMPLE_W];
            end else if (flags.step) begin
                acc <= flags.beam_done ? '0 : beam_now;
                if (flags.beam_done && cur_angle == sel_angle) beam_out <= beam_now;
            end
        end
    end

    bf_power_track #(
        .NUM_ANGLES(NUM_ANGLES), .BEAM_W(BEAM_W), .EN_W(EN_W), .ANG_W(ANG_W)
    ) u_power (
        .clk(clk), .rst(rst), .flags(flags), .angle(cur_angle), .beam(beam_now),
        .dom_valid(dom_valid), .dom_angle(dom_angle), .dom_energy(dom_energy)
    );

    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (flags.step && sample_valid) |=> $stable(mic_out)); // R5

endmodule

// File: tb/test_bf_scan_beamformer.sv
module test_bf_scan_beamformer;
    localparam int NM = 4;
    localparam int NA = 8;
    localparam int WL = 4;
    localparam int LM = 2;
    localparam int SW = 16;
    localparam int AW = 3;
    localparam int MW = 2;
    localparam int BW = 18;
    localparam int EW = 40;

    localparam logic [63:0] STIM [12] = '{
        64'h0400_0300_0200_0100, 64'h7FFF_7FFF_7FFF_7FFF, 64'h8000_8000_8000_8000,
        64'hFFFF_0001_FFFF_0001, 64'h1234_EDCC_0F0F_F0F1, 64'h0000_0000_0000_7FFF,
        64'h8000_0000_0000_0000, 64'h0040_0030_0020_0010, 64'hC000_4000_C000_4000,
        64'h0000_0000_0000_0000, 64'h5555_4444_3333_2222, 64'hFFFB_FFFC_FFFD_FFFE
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sample_valid = 1'b0;
    logic [NM*SW-1:0]     sample_in = '0;
    logic                 long_mode = 1'b0;
    logic [AW-1:0]        sel_angle = '0;
    logic [MW-1:0]        sel_mic = '0;
    logic                 done;
    logic signed [BW-1:0] beam_out;
    logic signed [SW-1:0] mic_out;
    logic                 dom_valid;
    logic [AW-1:0]        dom_angle;
    logic [EW-1:0]        dom_energy;

    int     n_checks = 0;
    int     n_fail = 0;
    int     hist [NM][256];
    int     nsamp = 0;
    longint en_m [NA];
    int     wcnt = 0;
    bit     wlong = 1'b0;

    always #2 clk = ~clk;

    bf_scan_beamformer #(
        .NUM_MICS(NM), .NUM_ANGLES(NA), .SAMPLE_W(SW), .DEPTH(64),
        .WINDOW_LEN(WL), .LONG_MULT(LM)
    ) i_bf_scan_beamformer (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
        .long_mode(long_mode), .sel_angle(sel_angle), .sel_mic(sel_mic),
        .done(done), .beam_out(beam_out), .mic_out(mic_out),
        .dom_valid(dom_valid), .dom_angle(dom_angle), .dom_energy(dom_energy)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint exp_beam(input int a);
        longint s = 0;
        for (int m = 0; m < NM; m++) begin
            int idx = nsamp - 1 - ((a * (2 * m + 1) + 3 * m) % 64);
            if (idx >= 0) s += hist[m][idx];
        end
        return s;
    endfunction

    task automatic send(input logic [63:0] v, input bit inject);
        int     waited;
        bit     wend;
        int     best;
        logic [AW-1:0] prev_dom;
        prev_dom = dom_angle;
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in = v;
        for (int m = 0; m < NM; m++) hist[m][nsamp] = int'($signed(v[m*SW +: SW]));
        nsamp++;
        if (wcnt == 0) wlong = long_mode;
        wcnt++;
        for (int a = 0; a < NA; a++) en_m[a] += exp_beam(a) * exp_beam(a);
        wend = (wcnt == (wlong ? WL * LM : WL));
        @(negedge clk);
        sample_valid = 1'b0;
        waited = 1;
        while (!done && waited < 500) begin
            if (inject && waited == 4) begin
                sample_valid = 1'b1;
                sample_in = ~v;
            end else begin
                sample_valid = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        sample_valid = 1'b0;
        check("R4 done latency", waited, NA * NM + 1);
        check(nsamp > 64 ? "R10 wrapped beam" : "R3 beam", beam_out, exp_beam(int'(sel_angle)));
        check(inject ? "R5 mic after busy pulse" : "R2 mic", mic_out, hist[sel_mic][nsamp-1]);
        check(wlong ? "R7 window end" : "R6 window end", dom_valid, wend);
        if (wend) begin
            best = 0;
            for (int a = 1; a < NA; a++) if (en_m[a] > en_m[best]) best = a;
            check("R8 dominant", dom_angle, best);
            check("R6 energy", dom_energy, en_m[best]);
            for (int a = 0; a < NA; a++) en_m[a] = 0;
            wcnt = 0;
        end else begin
            check("R9 dom held", dom_angle, prev_dom);
        end
        @(negedge clk);
        check("R4 done single", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) en_m[a] = 0;
        repeat (4) @(negedge clk);
        check("R1 done in reset", done, 0);
        check("R1 beam in reset", beam_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mic after reset", mic_out, 0);
        check("R1 dom_valid after reset", dom_valid, 0);
        check("R1 dom_angle after reset", dom_angle, 0);
        check("R1 dom_energy after reset", dom_energy, 0);

        // R8: all-zero window, every direction ties at zero
        sel_angle = 3'd5;
        for (int i = 0; i < WL; i++) send(64'h0, 1'b0);

        // table of mixed frames, selection varies per row
        for (int i = 0; i < 12; i++) begin
            sel_angle = AW'(i % NA);
            sel_mic = MW'(i % NM);
            send(STIM[i], 1'b0);
        end

        // R5 busy injection, R7 mode change in mid-window
        sel_angle = 3'd2;
        sel_mic = 2'd1;
        send(64'h0123_4567_89AB_CDEF, 1'b1);
        send(64'h1111_2222_3333_4444, 1'b1);
        long_mode = 1'b1;
        send(64'hF000_0F00_00F0_000F, 1'b0);
        send(64'h7000_9000_7000_9000, 1'b0);
        for (int i = 0; i < WL * LM; i++) send({16'(i * 311), 16'(-i * 97), 16'(i * 4001), 16'(i)}, 1'b0);
        long_mode = 1'b0;

        // R10 ramp past buffer depth
        for (int i = 0; i < 70; i++) begin
            sel_angle = AW'(7 - (i % NA));
            sel_mic = MW'(i % NM);
            send({16'(i * 1237), 16'(i * 4099 + 5), 16'(-i * 733), 16'(i * 29 - 700)}, 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule